// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block is a non-blocking time and space switch for serial PCM streams. It receives 16 serial input lines. Every complete input byte is stored in a speech memory with two banks, one for the frame being received and one for the frame before it. On each of 8 serial output lines, every output slot can carry any stored input channel. The choice is made by a connection table with one entry per output line and slot. A simple write port loads that table. Each entry also says whether the slot drives its line or stays in high impedance, so several switches can share output lines for expansion or tandem use.

Each entry also picks the delay behaviour of its slot. In constant mode the slot always carries the byte received one frame earlier, so all slots see the same delay. In minimal mode the slot carries the byte of the current frame whenever that byte was complete before the output slot began. The input and output line rates are set separately. A read port returns the byte most recently completed for any input line and slot.

Top module: `tsi_switch`

## Requirements
- R1: A frame is 1024 clocks long. Its position counts up by one per clock and wraps. A cycle with `fsync_i` high is position 0, which is bit 0 of slot 0 on every input and output line.
- R2: The input rate code sets how long each bit lasts: 0 gives 4 clocks per bit (32 slots), 1 gives 2 clocks (64 slots), and 2 or 3 gives 1 clock (128 slots). Bits arrive MSB first. Bit k of slot s starts at position (8s+k)·C, where C is the clocks per bit, and is sampled at offset C/2 within its bit period.
- R3: The output rate code is independent of the input rate code and uses the same encoding and MSB-first order. The pin values present after the clock edge that samples position p belong to position p.
- R4: Any input line and slot can feed any output line and slot. All 8 output lines carry their selections at the same time, including two outputs that carry the same source.
- R5: In constant-delay mode a driven slot carries the source byte received during the previous frame.
- R6: In minimal-delay mode a driven slot carries the current-frame source byte when the position that samples the last bit of that source is strictly lower than the start position of the output slot. Otherwise it carries the previous-frame byte.
- R7: A slot whose entry has the drive bit clear holds `pcm_oe_o` low and `pcm_out_o` at 0 for the whole slot. A slot with the drive bit set holds `pcm_oe_o` high for the whole slot.
- R8: After reset every output line is undriven and the read data is 0, until connection entries are written and have taken effect.
- R9: A connection word has the source slot in bits [6:0], the source line in bits [10:7], the minimal-delay select in bit 11 and the drive enable in bit 12. A write changes nothing in the frame in which it is made and takes effect from the next frame.
- R10: One clock after a read address is presented, `rd_data_o` holds the byte of that input line and slot from the most recently completed frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Device clock, one clock per bit at the fastest rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fsync_i | input | 1 | Frame start, high for one clock at position 0 |
| in_rate_i | input | 2 | Input line rate code |
| out_rate_i | input | 2 | Output line rate code |
| pcm_in_i | input | 16 | Serial input lines |
| pcm_out_o | output | 8 | Serial output data |
| pcm_oe_o | output | 8 | Output drive enable, one per line |
| cm_we_i | input | 1 | Connection table write strobe |
| cm_line_i | input | 3 | Output line of the entry being written |
| cm_slot_i | input | 7 | Output slot of the entry being written |
| cm_data_i | input | 13 | Connection word |
| rd_line_i | input | 4 | Input line to read back |
| rd_slot_i | input | 7 | Input slot to read back |
| rd_data_o | output | 8 | Stored byte for the read address |

## Verification
A wrong bank select shows up within one output slot: a mapped slot carries the byte of the wrong frame. Because every frame of test data is different, this is visible at once. If a position or bit counter slips, every bit that follows is shifted, and the first slot checked after the slip shows it. If the connection table commits at the wrong time, the enable pattern changes one frame early or late. The minimal-delay boundary is checked on both sides for three combinations of input and output rates, so a comparison that is off by one shows up as a previous-frame byte where a current-frame byte was expected, or the other way round.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    typedef enum logic [1:0] {
        RATE_SLOW = 2'd0,
        RATE_MID  = 2'd1,
        RATE_FAST = 2'd2,
        RATE_ALT  = 2'd3
    } line_rate_e;

    // log2 of clocks per bit for a rate code
    function automatic logic [1:0] rate_shift(input logic [1:0] code);
        case (line_rate_e'(code))
            RATE_SLOW: return 2'd2;
            RATE_MID:  return 2'd1;
            default:   return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/tsi_timing.sv
module tsi_timing
    import tsi_pkg::*;
#(
    parameter int MAX_SLOTS = 128,
    localparam int SLOT_W = $clog2(MAX_SLOTS),
    localparam int POS_W  = SLOT_W + 3,
    localparam int LAST   = MAX_SLOTS * 8 - 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              fsync_i,
    input  logic [1:0]        in_rate_i,
    input  logic [1:0]        out_rate_i,
    output logic [POS_W-1:0]  pos_o,
    output logic              frame_end_o,
    output logic              bank_o,
    output logic              in_sample_o,
    output logic              in_done_o,
    output logic [SLOT_W-1:0] in_slot_o,
    output logic [SLOT_W-1:0] out_slot_o,
    output logic [2:0]        out_bit_o,
    output logic              out_bit_start_o,
    output logic              out_slot_start_o
);

    typedef struct packed {
        logic [POS_W-1:0] cnt;
        logic             bank;
    } tstate_t;

    tstate_t st_d, st_q;

    logic [POS_W-1:0] pos, in_idx, out_idx, in_len, out_len;
    logic [1:0]       lg_in, lg_out;

    always_comb begin
        pos     = fsync_i ? '0 : st_q.cnt;
        lg_in   = rate_shift(in_rate_i);
        lg_out  = rate_shift(out_rate_i);
        in_len  = POS_W'(1) << lg_in;
        out_len = POS_W'(1) << lg_out;
        in_idx  = pos >> lg_in;
        out_idx = pos >> lg_out;

        in_sample_o      = (pos & (in_len - POS_W'(1))) == (in_len >> 1);
        in_done_o        = in_sample_o && (in_idx[2:0] == 3'd7);
        in_slot_o        = in_idx[POS_W-1:3];
        out_bit_start_o  = (pos & (out_len - POS_W'(1))) == '0;
        out_slot_start_o = out_bit_start_o && (out_idx[2:0] == 3'd0);
        out_bit_o        = out_idx[2:0];
        out_slot_o       = out_idx[POS_W-1:3];
        frame_end_o      = (pos == POS_W'(LAST));
        pos_o            = pos;
        bank_o           = st_q.bank;

        st_d.cnt  = pos + POS_W'(1);
        st_d.bank = frame_end_o ? ~st_q.bank : st_q.bank;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

endmodule

// File: rtl/tsi_rx_line.sv
module tsi_rx_line (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       din_i,
    input  logic       sample_i,
    output logic [7:0] byte_o
);

    typedef struct packed {
        logic [6:0] sh;
    } rstate_t;

    rstate_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        if (sample_i) st_d.sh = {st_q.sh[5:0], din_i};
        byte_o = {st_q.sh, din_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

endmodule

// File: rtl/tsi_tx_line.sv
module tsi_tx_line (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       slot_start_i,
    input  logic       bit_start_i,
    input  logic [2:0] bit_i,
    input  logic [7:0] byte_i,
    input  logic       en_i,
    output logic       dout_o,
    output logic       oe_o
);

    typedef struct packed {
        logic [7:0] held;
        logic       en;
        logic       dout;
        logic       oe;
    } xstate_t;

    xstate_t st_d, st_q;
    logic [7:0] cur_byte;
    logic       cur_en;

    always_comb begin
        st_d     = st_q;
        cur_byte = slot_start_i ? byte_i : st_q.held;
        cur_en   = slot_start_i ? en_i   : st_q.en;
        st_d.held = cur_byte;
        st_d.en   = cur_en;
        if (bit_start_i) begin
            st_d.dout = cur_en & cur_byte[3'd7 - bit_i];
            st_d.oe   = cur_en;
        end
        dout_o = st_q.dout;
        oe_o   = st_q.oe;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem #(
    parameter int N_OUT     = 8,
    parameter int MAX_SLOTS = 128,
    parameter int CONN_W    = 13,
    localparam int OLINE_W  = $clog2(N_OUT),
    localparam int SLOT_W   = $clog2(MAX_SLOTS)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               we_i,
    input  logic [OLINE_W-1:0] wline_i,
    input  logic [SLOT_W-1:0]  wslot_i,
    input  logic [CONN_W-1:0]  wdata_i,
    input  logic               commit_i,
    input  logic [SLOT_W-1:0]  rd_slot_i,
    output logic [CONN_W-1:0]  rd_data_o [N_OUT]
);

    logic [CONN_W-1:0] pend_q [N_OUT][MAX_SLOTS];
    logic [CONN_W-1:0] live_q [N_OUT][MAX_SLOTS];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int o = 0; o < N_OUT; o++)
                for (int s = 0; s < MAX_SLOTS; s++) begin
                    pend_q[o][s] <= '0;
                    live_q[o][s] <= '0;
                end
        end else begin
            for (int o = 0; o < N_OUT; o++)
                for (int s = 0; s < MAX_SLOTS; s++) begin
                    if (we_i && wline_i == OLINE_W'(o) && wslot_i == SLOT_W'(s)) begin
                        pend_q[o][s] <= wdata_i;
                        if (commit_i) live_q[o][s] <= wdata_i;
                    end else if (commit_i) begin
                        live_q[o][s] <= pend_q[o][s];
                    end
                end
        end
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_rd
        assign rd_data_o[o] = live_q[o][rd_slot_i];
    end

endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
    import tsi_pkg::*;
#(
    parameter int N_IN      = 16,
    parameter int N_OUT     = 8,
    parameter int MAX_SLOTS = 128,
    localparam int LINE_W   = $clog2(N_IN),
    localparam int OLINE_W  = $clog2(N_OUT),
    localparam int SLOT_W   = $clog2(MAX_SLOTS),
    localparam int POS_W    = SLOT_W + 3,
    localparam int CONN_W   = 2 + LINE_W + SLOT_W
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               fsync_i,
    input  logic [1:0]         in_rate_i,
    input  logic [1:0]         out_rate_i,
    input  logic [N_IN-1:0]    pcm_in_i,
    output logic [N_OUT-1:0]   pcm_out_o,
    output logic [N_OUT-1:0]   pcm_oe_o,
    input  logic               cm_we_i,
    input  logic [OLINE_W-1:0] cm_line_i,
    input  logic [SLOT_W-1:0]  cm_slot_i,
    input  logic [CONN_W-1:0]  cm_data_i,
    input  logic [LINE_W-1:0]  rd_line_i,
    input  logic [SLOT_W-1:0]  rd_slot_i,
    output logic [7:0]         rd_data_o
);

    logic [POS_W-1:0]  pos;
    logic              frame_end, bank, in_sample, in_done;
    logic [SLOT_W-1:0] in_slot, out_slot;
    logic [2:0]        out_bit;
    logic              out_bit_start, out_slot_start;

    tsi_timing #(.MAX_SLOTS(MAX_SLOTS)) u_timing (
        .clk_i           (clk_i),
        .rst_ni          (rst_ni),
        .fsync_i         (fsync_i),
        .in_rate_i       (in_rate_i),
        .out_rate_i      (out_rate_i),
        .pos_o           (pos),
        .frame_end_o     (frame_end),
        .bank_o          (bank),
        .in_sample_o     (in_sample),
        .in_done_o       (in_done),
        .in_slot_o       (in_slot),
        .out_slot_o      (out_slot),
        .out_bit_o       (out_bit),
        .out_bit_start_o (out_bit_start),
        .out_slot_start_o(out_slot_start)
    );

    // receive side: one deserializer per input line
    logic [7:0] rx_byte [N_IN];

    for (genvar l = 0; l < N_IN; l++) begin : g_rx
        tsi_rx_line u_rx (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .din_i   (pcm_in_i[l]),
            .sample_i(in_sample),
            .byte_o  (rx_byte[l])
        );
    end

    // speech memory: line x bank x slot
    logic [7:0] spm_q [N_IN][2][MAX_SLOTS];

    always_ff @(posedge clk_i) begin
        if (in_done) begin
            for (int l = 0; l < N_IN; l++)
                spm_q[l][bank][in_slot] <= rx_byte[l];
        end
    end

    // connection table
    logic [CONN_W-1:0] conn [N_OUT];

    tsi_conn_mem #(.N_OUT(N_OUT), .MAX_SLOTS(MAX_SLOTS), .CONN_W(CONN_W)) u_cm (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .we_i     (cm_we_i),
        .wline_i  (cm_line_i),
        .wslot_i  (cm_slot_i),
        .wdata_i  (cm_data_i),
        .commit_i (frame_end),
        .rd_slot_i(out_slot),
        .rd_data_o(conn)
    );

    // position at which the last bit of an input slot is sampled
    logic [1:0]       lg_in;
    logic [POS_W+2:0] in_half;

    always_comb begin
        lg_in   = rate_shift(in_rate_i);
        in_half = (POS_W + 3)'((1 << lg_in) >> 1);
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_tx
        logic [LINE_W-1:0] src_line;
        logic [SLOT_W-1:0] src_slot;
        logic              src_min, src_en, use_cur, rd_bank;
        logic [POS_W+2:0]  done_pos;
        logic [7:0]        src_byte;

        always_comb begin
            src_slot = conn[o][SLOT_W-1:0];
            src_line = conn[o][LINE_W+SLOT_W-1:SLOT_W];
            src_min  = conn[o][CONN_W-2];
            src_en   = conn[o][CONN_W-1];
            done_pos = ((POS_W + 3)'({src_slot, 3'b111}) << lg_in) + in_half;
            use_cur  = src_min && (done_pos < (POS_W + 3)'(pos));
            rd_bank  = use_cur ? bank : ~bank;
            src_byte = spm_q[src_line][rd_bank][src_slot];
        end

        tsi_tx_line u_tx (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .slot_start_i(out_slot_start),
            .bit_start_i (out_bit_start),
            .bit_i       (out_bit),
            .byte_i      (src_byte),
            .en_i        (src_en),
            .dout_o      (pcm_out_o[o]),
            .oe_o        (pcm_oe_o[o])
        );
    end

    // processor read-back of the last completed frame
    typedef struct packed {
        logic [7:0] rd;
    } top_state_t;

    top_state_t st_d, st_q;

    always_comb begin
        st_d.rd   = spm_q[rd_line_i][~bank][rd_slot_i];
        rd_data_o = st_q.rd;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk #(
    parameter int N_OUT = 8,
    parameter int POS_W = 10
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             fsync_i,
    input logic [POS_W-1:0] pos_i,
    input logic             slot_start_i,
    input logic [N_OUT-1:0] pcm_out_i,
    input logic [N_OUT-1:0] pcm_oe_i
);

    AST_FSYNC_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fsync_i |=> (fsync_i || pos_i == POS_W'(1))); // R1

    AST_OE_HELD_IN_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(slot_start_i) |-> $stable(pcm_oe_i)); // R7

    AST_IDLE_LINE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pcm_out_i & ~pcm_oe_i) == '0); // R7

    AST_RESET_UNDRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(!rst_ni) |-> pcm_oe_i == '0); // R8

endmodule

bind tsi_switch tsi_switch_chk #(.N_OUT(N_OUT), .POS_W(POS_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fsync_i     (fsync_i),
    .pos_i       (pos),
    .slot_start_i(out_slot_start),
    .pcm_out_i   (pcm_out_o),
    .pcm_oe_i    (pcm_oe_o)
);

// File: tb/test_tsi_switch.sv
module test_tsi_switch;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        fsync = 1'b0;
    logic [1:0]  in_rate = 2'd2;
    logic [1:0]  out_rate = 2'd2;
    logic [15:0] pcm_in = '0;
    logic [7:0]  pcm_out, pcm_oe;
    logic        cm_we = 1'b0;
    logic [2:0]  cm_line = '0;
    logic [6:0]  cm_slot = '0;
    logic [12:0] cm_data = '0;
    logic [3:0]  rd_line = '0;
    logic [6:0]  rd_slot = '0;
    logic [7:0]  rd_data;

    always #10 clk = ~clk;

    tsi_switch i_tsi_switch (
        .clk_i(clk), .rst_ni(rst_ni), .fsync_i(fsync),
        .in_rate_i(in_rate), .out_rate_i(out_rate),
        .pcm_in_i(pcm_in), .pcm_out_o(pcm_out), .pcm_oe_o(pcm_oe),
        .cm_we_i(cm_we), .cm_line_i(cm_line), .cm_slot_i(cm_slot), .cm_data_i(cm_data),
        .rd_line_i(rd_line), .rd_slot_i(rd_slot), .rd_data_o(rd_data)
    );

    int nchk = 0;
    int nerr = 0;
    int fr = 0;

    logic [12:0] pend_m [8][128];
    logic [12:0] live_m [8][128];
    int          wq_n = 0;
    logic [2:0]  wq_o [64];
    logic [6:0]  wq_s [64];
    logic [12:0] wq_d [64];
    bit          rp_en = 0;
    logic [3:0]  rp_l = '0;
    logic [6:0]  rp_s = '0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] dbyte(input int f, input int l, input int s);
        return 8'(f * 29 + l * 17 + s * 5 + 1);
    endfunction

    function automatic int lgof(input logic [1:0] r);
        return (r == 2'd0) ? 2 : (r == 2'd1) ? 1 : 0;
    endfunction

    task automatic qwrite(input int o, input int s, input bit en, input bit mn, input int l, input int si);
        logic [12:0] d;
        d = {en, mn, 4'(l), 7'(si)};
        wq_o[wq_n] = 3'(o); wq_s[wq_n] = 7'(s); wq_d[wq_n] = d;
        wq_n++;
        pend_m[o][s] = d;
    endtask

    task automatic clear_all();
        for (int o = 0; o < 8; o++)
            for (int s = 0; s < 128; s++)
                if (pend_m[o][s] != '0) qwrite(o, s, 0, 0, 0, 0);
    endtask

    // one frame: drive inputs, queued writes and read probe; compare every output position
    task automatic run_frame(input bit chk_en, input string tag);
        bit   bad [8];
        int   act_v [8];
        int   exp_v [8];
        int   li, lo;
        li = lgof(in_rate);
        lo = lgof(out_rate);
        for (int o = 0; o < 8; o++) begin bad[o] = 0; act_v[o] = 0; exp_v[o] = 0; end
        for (int p = 0; p < 1024; p++) begin
            fsync = (p == 0);
            for (int l = 0; l < 16; l++) begin
                logic [7:0] b;
                int ib;
                ib = p >> li;
                b = dbyte(fr, l, ib >> 3);
                pcm_in[l] = b[7 - (ib & 7)];
            end
            cm_we = 1'b0;
            if (p >= 500 && (p - 500) < wq_n) begin
                cm_we = 1'b1;
                cm_line = wq_o[p - 500]; cm_slot = wq_s[p - 500]; cm_data = wq_d[p - 500];
            end
            if (rp_en && p == 300) begin rd_line = rp_l; rd_slot = rp_s; end
            @(posedge clk);
            @(negedge clk);
            for (int o = 0; o < 8; o++) begin
                int ob, s, k, wp, ps;
                logic [12:0] e;
                logic [7:0]  b;
                logic [1:0]  expv, actv;
                ob = p >> lo; s = ob >> 3; k = ob & 7;
                e = live_m[o][s];
                expv = 2'b00;
                if (e[12]) begin
                    wp = ((int'(e[6:0]) * 8 + 7) << li) + ((1 << li) >> 1);
                    ps = (s * 8) << lo;
                    b = (e[11] && wp < ps) ? dbyte(fr, e[10:7], e[6:0])
                                           : dbyte(fr - 1, e[10:7], e[6:0]);
                    expv = {1'b1, b[7 - k]};
                end
                actv = {pcm_oe[o], pcm_out[o]};
                if (actv != expv && !bad[o]) begin
                    bad[o] = 1;
                    act_v[o] = (p << 8) | (o << 4) | int'(actv);
                    exp_v[o] = (p << 8) | (o << 4) | int'(expv);
                end
            end
            if (chk_en && rp_en && p == 300)
                check(rd_data == dbyte(fr - 1, rp_l, rp_s), "R10", rd_data, dbyte(fr - 1, rp_l, rp_s));
        end
        cm_we = 1'b0;
        wq_n = 0;
        for (int o = 0; o < 8; o++)
            for (int s = 0; s < 128; s++) live_m[o][s] = pend_m[o][s];
        if (chk_en)
            for (int o = 0; o < 8; o++) check(!bad[o], tag, act_v[o], exp_v[o]);
        fr++;
    endtask

    task automatic t_reset();
        check(pcm_oe == '0, "R8", pcm_oe, 0);
        check(rd_data == '0, "R8", rd_data, 0);
        run_frame(1, "R8");
    endtask

    task automatic t_commit();
        qwrite(0, 0, 1, 0, 15, 127);
        qwrite(1, 127, 1, 0, 0, 0);
        qwrite(2, 64, 1, 0, 7, 64);
        qwrite(3, 5, 1, 0, 7, 64);
        for (int o = 4; o < 8; o++) qwrite(o, 10, 1, 0, o - 1, 9 + o);
        run_frame(1, "R9");
    endtask

    task automatic t_constant();
        run_frame(1, "R1 R4 R5");
    endtask

    task automatic t_minimal();
        clear_all();
        qwrite(0, 10, 1, 1, 3, 3);
        qwrite(1, 10, 1, 1, 4, 10);
        qwrite(2, 5, 1, 1, 5, 100);
        qwrite(3, 127, 1, 1, 6, 126);
        qwrite(4, 1, 1, 1, 8, 0);
        run_frame(1, "R9");
        run_frame(1, "R6");
    endtask

    task automatic t_tristate();
        clear_all();
        qwrite(0, 20, 1, 0, 2, 3);
        qwrite(0, 21, 0, 1, 2, 3);
        qwrite(0, 22, 1, 1, 2, 3);
        qwrite(6, 40, 0, 0, 15, 127);
        run_frame(1, "R9");
        run_frame(1, "R7");
    endtask

    task automatic t_rates_slow_in();
        in_rate = 2'd0; out_rate = 2'd2;
        clear_all();
        qwrite(0, 12, 1, 1, 2, 2);
        qwrite(1, 11, 1, 1, 2, 2);
        qwrite(2, 100, 1, 0, 9, 31);
        qwrite(3, 127, 1, 1, 11, 31);
        run_frame(0, "");
        run_frame(1, "R2 R3 R6");
    endtask

    task automatic t_rates_slow_out();
        in_rate = 2'd2; out_rate = 2'd0;
        clear_all();
        qwrite(0, 3, 1, 1, 1, 11);
        qwrite(1, 3, 1, 1, 1, 12);
        qwrite(5, 31, 1, 0, 14, 127);
        qwrite(7, 0, 1, 1, 0, 0);
        run_frame(0, "");
        run_frame(1, "R2 R3 R6");
    endtask

    task automatic t_mid_rates();
        in_rate = 2'd1; out_rate = 2'd1;
        clear_all();
        qwrite(2, 63, 1, 0, 12, 63);
        qwrite(4, 20, 1, 1, 13, 19);
        run_frame(0, "");
        run_frame(1, "R2 R3 R5");
    endtask

    task automatic t_pcm_read();
        in_rate = 2'd2; out_rate = 2'd2;
        run_frame(0, "");
        rp_en = 1; rp_l = 4'd15; rp_s = 7'd127;
        run_frame(1, "R10");
        rp_l = 4'd0; rp_s = 7'd5;
        run_frame(1, "R10");
        rp_en = 0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        nchk++; nerr++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int o = 0; o < 8; o++)
            for (int s = 0; s < 128; s++) begin pend_m[o][s] = '0; live_m[o][s] = '0; end
        repeat (4) @(negedge clk);
        rst_ni = 1'b1;
        @(negedge clk);
        t_reset();
        t_commit();
        t_constant();
        t_minimal();
        t_tristate();
        t_rates_slow_in();
        t_rates_slow_out();
        t_mid_rates();
        t_pcm_read();
        finish_run();
    end

endmodule